// File: doc/BRIEF.md
# Multi-Bank DRAM Open-Page Tracker

This block decides, for every memory request, whether the addressed DRAM page is already open. It splits the request address into a bank index, a row and a column. It compares the row with the row held open for that bank. It then returns one of three results: hit, miss (the open row must be closed first) or idle (the bank has no open row and only needs an activate). A memory controller uses this result to choose its command sequence. Command sequencing, refresh and the data path stay outside this block.

In region mode each bank owns one contiguous slice of the address space, and the slice is chosen by the top address bits. Each bank has its own open-row register, its own comparator and its own active-time counter, so up to one page per bank can stay open at once. In interleaved mode the low address bits pick the bank. A single shared row register, comparator and counter then track one wide page that is spread across all banks. When a counter runs out, the page is dropped and a one-cycle precharge request is raised for the affected bank or banks.

Top module: `dram_page_tracker`

## Requirements
- R1: In region mode (INTERLEAVE=0) the address splits as {bank, row, column}: the bank is the top log2(NUM_BANKS) bits, the column is the low COL_W bits, and the row is the bits between them.
- R2: In interleaved mode (INTERLEAVE=1) the address splits as {row, column, bank}: the bank is the low log2(NUM_BANKS) bits, the column is the next COL_W bits, and the row is the top bits.
- R3: `req_ready` is high from the first clock edge after reset is released. For each request accepted at an edge, `rsp_valid` is high after that same edge, together with `rsp_bank`, `rsp_row` and `rsp_result`. After an edge with no accepted request, `rsp_valid` is low.
- R4: `rsp_result` is 2'b00 (hit) when the page is open with the same row, 2'b01 (miss) when the page is open with a different row, and 2'b10 (idle) when no page is open. The value 2'b11 is never produced.
- R5: An accepted request loads the addressed page tracker with the new row, marks it open and reloads its counter with TIMEOUT_CYCLES. A hit also reloads the counter.
- R6: In region mode each bank tracks its own page, so requests that alternate between banks hit on every bank's open row.
- R7: If a page gets no request for TIMEOUT_CYCLES edges after its last access, it closes at the TIMEOUT_CYCLES-th edge. At that edge the matching `precharge_req` bit goes high for exactly one cycle, and the next access to that page reports idle.
- R8: A request that arrives at the edge where its page would expire takes priority. It is judged against the still-open row, no precharge pulse is raised, and the counter is reloaded.
- R9: In interleaved mode a single page is shared by all banks. A request to any bank with the open row hits, and an expiry raises every bit of `precharge_req` together.
- R10: After reset every page is closed, `rsp_valid` and `precharge_req` are low, and the first access to any bank reports idle.
- R11: NUM_BANKS must be 2, 4 or 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_ready | output | 1 | Block accepts a request this cycle |
| rsp_valid | output | 1 | Decision for the request accepted at the last edge |
| rsp_bank | output | log2(NUM_BANKS) | Decoded bank index |
| rsp_row | output | ADDR_W-log2(NUM_BANKS)-COL_W | Decoded row address |
| rsp_result | output | 2 | 00 hit, 01 miss, 10 idle |
| precharge_req | output | NUM_BANKS | One-cycle close request, one bit per bank |

## Verification
The bench builds two instances side by side, both with a 12-bit address, a 3-bit column and TIMEOUT_CYCLES=6. The first is a four-bank region-mode tracker and the second is an eight-bank interleaved tracker. The short timeout means an expiry, and a request that lands exactly on the expiring edge, both happen within a few cycles. The narrow address lets every field value the checks use be written out by hand. The eight-bank interleaved build exercises the widest bank field and the all-bank precharge fan-out.

// File: rtl/dpt_pkg.sv
// Shared types for the open-page tracker.
// Assumes: result codes are fixed by the controller that consumes them.
package dpt_pkg;
    typedef enum logic [1:0] {
        PG_HIT  = 2'b00,
        PG_MISS = 2'b01,
        PG_IDLE = 2'b10
    } pg_result_e;
endpackage

// File: rtl/dpt_addr_decode.sv
// Splits a request address into bank, row and column fields.
// Assumes: ADDR_W > BANK_W + COL_W; INTERLEAVE picks low-bit bank selection.
module dpt_addr_decode #(
    parameter int ADDR_W     = 24,
    parameter int BANK_W     = 2,
    parameter int COL_W      = 10,
    parameter bit INTERLEAVE = 1'b0,
    localparam int ROW_W     = ADDR_W - BANK_W - COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    generate
        if (INTERLEAVE) begin : g_low_bank
            // Interleaved layout: {row, column, bank}
            assign bank = addr[BANK_W-1:0];
            assign col  = addr[BANK_W +: COL_W];
            assign row  = addr[ADDR_W-1 -: ROW_W];
        end else begin : g_high_bank
            // Region layout: {bank, row, column}
            assign bank = addr[ADDR_W-1 -: BANK_W];
            assign row  = addr[COL_W +: ROW_W];
            assign col  = addr[COL_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/dpt_page_slot.sv
// One open-page tracker: row register, valid flag, compare and active-time counter.
// Assumes: 'access' is high for at most one slot per cycle and always wins
// over an expiry in the same cycle.
module dpt_page_slot
    import dpt_pkg::*;
#(
    parameter int ROW_W          = 8,
    parameter int TIMEOUT_CYCLES = 64,
    localparam int CNT_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    input  logic [ROW_W-1:0] acc_row,
    output pg_result_e       result,
    output logic             expire
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] cnt_q;
    logic             expire_q;

    // Compare the presented row with the open page.
    always_comb begin
        if (!open_q)              result = PG_IDLE;
        else if (row_q == acc_row) result = PG_HIT;
        else                      result = PG_MISS;
    end

    // Open on access, count down while idle, close and pulse at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q   <= 1'b0;
            row_q    <= '0;
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (access) begin
                open_q <= 1'b1;
                row_q  <= acc_row;
                cnt_q  <= CNT_W'(TIMEOUT_CYCLES);
            end else if (open_q) begin
                if (cnt_q <= CNT_W'(1)) begin
                    open_q   <= 1'b0;
                    cnt_q    <= '0;
                    expire_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign expire = expire_q;

    // R5: an access leaves the page open on the new row
    a_r5_access_opens: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> (open_q && row_q == $past(acc_row)));
    // R8: an access edge never produces an expiry pulse
    a_r8_access_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !expire_q);
    // R7: the precharge pulse lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |=> !expire_q);
    // R7: the counter stays within its reload value
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(TIMEOUT_CYCLES));
endmodule

// File: rtl/dram_page_tracker.sv
// Open-page hit/miss decision unit for a multi-bank DRAM controller.
// Assumes: one request per cycle; the response is registered one edge later;
// in interleaved mode a single slot tracks a page spread over all banks.
module dram_page_tracker
    import dpt_pkg::*;
#(
    parameter int ADDR_W         = 24,
    parameter int NUM_BANKS      = 4,
    parameter int COL_W          = 10,
    parameter bit INTERLEAVE     = 1'b0,
    parameter int TIMEOUT_CYCLES = 64,
    localparam int BANK_W        = $clog2(NUM_BANKS),
    localparam int ROW_W         = ADDR_W - BANK_W - COL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [BANK_W-1:0]    rsp_bank,
    output logic [ROW_W-1:0]     rsp_row,
    output logic [1:0]           rsp_result,
    output logic [NUM_BANKS-1:0] precharge_req
);
    localparam int NUM_SLOTS = INTERLEAVE ? 1 : NUM_BANKS;
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    // R11: legal bank counts
    initial begin
        a_r11_bank_count: assert (NUM_BANKS == 2 || NUM_BANKS == 4 || NUM_BANKS == 8)
            else $error("NUM_BANKS must be 2, 4 or 8");
    end

    logic                 ready_q;
    logic                 req_fire;
    logic [BANK_W-1:0]    dec_bank;
    logic [ROW_W-1:0]     dec_row;
    logic [COL_W-1:0]     dec_col;
    logic [SLOT_W-1:0]    slot_sel;
    logic [NUM_SLOTS-1:0] slot_access;
    logic [NUM_SLOTS-1:0] slot_expire;
    pg_result_e           slot_result [NUM_SLOTS];
    pg_result_e           sel_result;

    // Accept requests from the first edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign req_ready = ready_q;
    assign req_fire  = req_valid && ready_q;

    dpt_addr_decode #(
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W),
        .COL_W     (COL_W),
        .INTERLEAVE(INTERLEAVE)
    ) u_decode (
        .addr(req_addr),
        .bank(dec_bank),
        .row (dec_row),
        .col (dec_col)
    );

    generate
        if (INTERLEAVE) begin : g_shared
            // One slot covers every bank.
            assign slot_sel      = '0;
            assign precharge_req = {NUM_BANKS{slot_expire[0]}};
        end else begin : g_per_bank
            // One slot per bank region.
            assign slot_sel      = SLOT_W'(dec_bank);
            assign precharge_req = slot_expire;
        end

        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            assign slot_access[s] = req_fire && (slot_sel == SLOT_W'(s));
            dpt_page_slot #(
                .ROW_W         (ROW_W),
                .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
            ) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .access (slot_access[s]),
                .acc_row(dec_row),
                .result (slot_result[s]),
                .expire (slot_expire[s])
            );
        end
    endgenerate

    // Pick the decision of the addressed slot.
    always_comb begin
        sel_result = PG_IDLE;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (slot_access[s]) sel_result = slot_result[s];
        end
    end

    // Register the response for the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_bank   <= '0;
            rsp_row    <= '0;
            rsp_result <= 2'b00;
        end else begin
            rsp_valid <= req_fire;
            if (req_fire) begin
                rsp_bank   <= dec_bank;
                rsp_row    <= dec_row;
                rsp_result <= sel_result;
            end
        end
    end

    // R3: a response follows every accepted request
    a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R3: no response without a request
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);
    // R4: the unused code never appears
    a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_result != 2'b11));
    // R3: the decision carries the decoded bank of the request
    a_r3_bank_match: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_bank == $past(dec_bank)));
endmodule

// File: tb/dram_page_tracker_bench.sv
`timescale 1ns/1ps
module dram_page_tracker_bench;
    localparam int AW = 12;
    localparam int CW = 3;
    localparam int TO = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // region-mode instance (4 banks: bank 2b, row 7b, col 3b)
    logic        req_valid = 1'b0;
    logic [11:0] req_addr  = '0;
    logic        req_ready, rsp_valid;
    logic [1:0]  rsp_bank;
    logic [6:0]  rsp_row;
    logic [1:0]  rsp_result;
    logic [3:0]  pre;

    // interleaved instance (8 banks: row 6b, col 3b, bank 3b)
    logic        il_valid = 1'b0;
    logic [11:0] il_addr  = '0;
    logic        il_ready, il_rsp_valid;
    logic [2:0]  il_bank;
    logic [5:0]  il_row;
    logic [1:0]  il_result;
    logic [7:0]  il_pre;

    dram_page_tracker #(.ADDR_W(AW), .NUM_BANKS(4), .COL_W(CW),
                        .INTERLEAVE(1'b0), .TIMEOUT_CYCLES(TO)) u_dram_page_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_bank(rsp_bank),
        .rsp_row(rsp_row), .rsp_result(rsp_result), .precharge_req(pre));

    dram_page_tracker #(.ADDR_W(AW), .NUM_BANKS(8), .COL_W(CW),
                        .INTERLEAVE(1'b1), .TIMEOUT_CYCLES(TO)) u_dram_page_tracker_il (
        .clk(clk), .rst_n(rst_n), .req_valid(il_valid), .req_addr(il_addr),
        .req_ready(il_ready), .rsp_valid(il_rsp_valid), .rsp_bank(il_bank),
        .rsp_row(il_row), .rsp_result(il_result), .precharge_req(il_pre));

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [1:0] HIT = 2'b00, MISS = 2'b01, IDLE = 2'b10;

    // vector: [13:12] bank, [11:5] row, [4:2] col, [1:0] expected result
    localparam logic [13:0] VEC [12] = '{
        {2'd0, 7'd5, 3'd0, IDLE},   // R10 first access idle
        {2'd1, 7'd9, 3'd1, IDLE},
        {2'd0, 7'd5, 3'd7, HIT},
        {2'd2, 7'd3, 3'd2, IDLE},
        {2'd1, 7'd9, 3'd4, HIT},    // R6 bank 0 still open too
        {2'd0, 7'd6, 3'd0, MISS},
        {2'd0, 7'd5, 3'd3, MISS},
        {2'd3, 7'd0, 3'd0, IDLE},
        {2'd2, 7'd3, 3'd6, HIT},
        {2'd1, 7'd9, 3'd5, HIT},
        {2'd3, 7'd1, 3'd0, MISS},
        {2'd0, 7'd5, 3'd2, HIT}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        il_valid = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        do_reset();
        // R10 / R3 reset state
        chk("R10 rsp_valid after reset", rsp_valid, 0);
        chk("R10 precharge after reset", pre, 0);
        chk("R10 il precharge after reset", il_pre, 0);
        chk("R3 ready after reset", req_ready, 1);

        // vector walk (R1 R4 R5 R6 R10)
        for (int i = 0; i < 12; i++) begin
            req_valid = 1'b1;
            req_addr  = {VEC[i][13:12], VEC[i][11:5], VEC[i][4:2]};
            step();
            chk("R3 rsp_valid", rsp_valid, 1);
            chk("R1 bank field", rsp_bank, VEC[i][13:12]);
            chk("R1 row field", rsp_row, VEC[i][11:5]);
            chk("R4 R6 result", rsp_result, VEC[i][1:0]);
        end
        req_valid = 1'b0;
        step();
        chk("R3 no request no response", rsp_valid, 0);

        // R7 timeout closes the page
        do_reset();
        req_valid = 1'b1;
        req_addr  = {2'd2, 7'd4, 3'd0};
        step();
        chk("R7 open bank 2", rsp_result, IDLE);
        req_valid = 1'b0;
        for (int k = 1; k < TO; k++) begin
            step();
            chk("R7 no early precharge", pre, 0);
        end
        step();
        chk("R7 precharge bank 2", pre, 4'b0100);
        step();
        chk("R7 pulse one cycle", pre, 0);
        req_valid = 1'b1;
        step();
        chk("R7 reopen reports idle", rsp_result, IDLE);
        req_valid = 1'b0;

        // R8 request on the expiring edge wins
        do_reset();
        req_valid = 1'b1;
        req_addr  = {2'd1, 7'd7, 3'd0};
        step();
        req_valid = 1'b0;
        for (int k = 1; k < TO; k++) step();
        chk("R8 still no precharge", pre, 0);
        req_valid = 1'b1;
        step();
        chk("R8 request wins as hit", rsp_result, HIT);
        chk("R8 no precharge on collision", pre, 0);
        req_valid = 1'b0;
        for (int k = 1; k < TO; k++) step();
        chk("R8 counter reloaded", pre, 0);
        step();
        chk("R8 expiry after reload", pre, 4'b0010);

        // R9 / R2 interleaved shared page
        do_reset();
        il_valid = 1'b1;
        il_addr  = {6'd10, 3'd0, 3'd3};
        step();
        chk("R9 il first idle", il_result, IDLE);
        chk("R2 il bank low bits", il_bank, 3);
        il_addr  = {6'd10, 3'd5, 3'd5};
        step();
        chk("R9 il other bank hits", il_result, HIT);
        chk("R2 il bank", il_bank, 5);
        chk("R2 il row high bits", il_row, 10);
        il_addr  = {6'd11, 3'd0, 3'd0};
        step();
        chk("R9 il new row misses", il_result, MISS);
        il_valid = 1'b0;
        for (int k = 1; k < TO; k++) step();
        chk("R9 il no early precharge", il_pre, 0);
        step();
        chk("R9 il precharge all banks", il_pre, 8'hFF);
        step();
        chk("R9 il pulse one cycle", il_pre, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule